// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Trap States

This block is the hardwired controller of a multicycle processor. Each instruction goes through a short chain of states: fetch, decode, then a path chosen by the opcode. Every path ends by going back to fetch. The controller drives every datapath control signal: instruction-register load, memory read and write, the memory address select, the ALU operand and operation selects, register-file write, and the PC update. It also drives the writes to the exception-PC and cause registers.

Five instruction kinds are supported:
- register-to-register ALU operations
- OR with a zero-extended immediate
- word load
- word store
- branch when two registers are equal

Two trap states handle faults. An opcode the decoder does not know sends the machine to one trap state. A signed overflow during a register ALU operation sends it to the other. In either trap, the ALU forms PC−4 so that the exception-PC register records the faulting instruction. A cause code is written, and the PC is loaded from a fixed handler vector. The next state is fetch.

The control outputs depend only on the current state. The single exception is `pc_en`, which gates the conditional branch write with the ALU zero flag.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low the state is 0000 (fetch). The fetch outputs are then present: `ir_write`=1, `mem_read`=1, `iord`=0, `pc_en`=1.
- R2: In fetch (0000) the controller reads memory at the PC and loads the IR. It adds PC+4 (`alu_src_a`=0, `alu_src_b`=001, `alu_op`=00 add) and writes it to the PC with `pc_source`=00. The next state is decode (0001).
- R3: In decode (0001) the ALU forms the branch target (`alu_src_a`=0, `alu_src_b`=011 shifted sign-extended immediate, add). Nothing is written. The state then dispatches on `opcode`: 000000 register ALU → 0100, 001101 OR-immediate → 0110, 100011 load → 1000, 101011 store → 1011, 000100 branch → 0010.
- R4: A register ALU operation runs 0100 then 0101, four cycles in all. State 0100 drives `alu_src_a`=1, `alu_src_b`=000, `alu_op`=10 (function field decides). State 0101 drives `reg_write`=1, `reg_dst`=1 (rd), `mem_to_reg`=0.
- R5: OR-immediate runs 0110 then 0111, four cycles. State 0110 drives `alu_src_b`=100 (zero-extended immediate) and `alu_op`=11 (OR). State 0111 writes rt (`reg_write`=1, `reg_dst`=0).
- R6: A load runs 1000, 1001, 1010, five cycles. State 1000 forms base+sign-extended offset (`alu_src_b`=010, add). State 1001 reads memory with `iord`=1. State 1010 writes rt with `mem_to_reg`=1. Memory read and write are never asserted together.
- R7: A store runs 1011 then 1100, four cycles. State 1100 asserts `mem_write` with `iord`=1, then returns to fetch.
- R8: A branch runs 0010 only, three cycles. State 0010 subtracts (`alu_src_a`=1, `alu_src_b`=000, `alu_op`=01) and selects `pc_source`=01. `pc_en` equals `zero` in that state.
- R9: An undefined opcode in decode leads to trap state 1101. In 1101 the controller:
  - drives PC−4 on the ALU (`alu_src_a`=0, `alu_src_b`=001, `alu_op`=01)
  - writes the exception PC
  - writes cause code 10
  - loads the PC from `handler_addr` (`pc_source`=10, default 0x80000180)
  
  The next state is fetch.
- R10: `overflow` high in state 0100 leads to trap state 1110 instead of 0101. State 1110 writes cause code 12 and the exception PC, redirects the PC as in R9, and asserts no `reg_write`. It then goes to fetch.
- R11: `overflow` has no effect outside state 0100, and `zero` has no effect on `pc_en` outside state 0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| zero | input | 1 | ALU result-is-zero flag |
| overflow | input | 1 | ALU signed overflow flag |
| state_o | output | 4 | Current state encoding |
| ir_write | output | 1 | Load instruction register |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| iord | output | 1 | Memory address: 0 PC, 1 ALU output register |
| pc_en | output | 1 | PC load enable (unconditional or zero-gated) |
| pc_source | output | 2 | PC input: 00 ALU, 01 ALU output register, 10 handler vector |
| alu_src_a | output | 1 | ALU A: 0 PC, 1 register A |
| alu_src_b | output | 3 | ALU B: 000 reg B, 001 four, 010 sign-ext, 011 sign-ext×4, 100 zero-ext |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field, 11 OR |
| reg_write | output | 1 | Register file write |
| reg_dst | output | 1 | Destination: 0 rt, 1 rd |
| mem_to_reg | output | 1 | Write data: 0 ALU output register, 1 memory data register |
| epc_write | output | 1 | Load exception-PC register |
| cause_write | output | 1 | Load cause register |
| cause_code | output | 5 | Cause value to record |
| handler_addr | output | 32 | Exception handler vector |

## Verification
A wrong next-state choice shows at the ports within one clock. `state_o` and the strobes belonging to that state are visibly wrong in the next cycle. For example, a missed overflow trap shows up as `reg_write` where `epc_write` was due. A wrong per-state output decode shows in the same cycle as the state itself, so every state on every path is checked field by field while the bench walks each instruction. The bench also counts the cycles until `state_o` returns to 0000. A path that is too long or too short is therefore caught at its last state.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int STATE_W = 4;
    localparam int OP_W    = 6;
    localparam int CAUSE_W = 5;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH    = 4'b0000,
        ST_DECODE   = 4'b0001,
        ST_BR       = 4'b0010,
        ST_R_EX     = 4'b0100,
        ST_R_WB     = 4'b0101,
        ST_ORI_EX   = 4'b0110,
        ST_ORI_WB   = 4'b0111,
        ST_LD_ADDR  = 4'b1000,
        ST_LD_MEM   = 4'b1001,
        ST_LD_WB    = 4'b1010,
        ST_ST_ADDR  = 4'b1011,
        ST_ST_MEM   = 4'b1100,
        ST_TRAP_OP  = 4'b1101,
        ST_TRAP_OVF = 4'b1110
    } state_e;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'b00,
        ALU_SUB   = 2'b01,
        ALU_FUNCT = 2'b10,
        ALU_OR    = 2'b11
    } alu_op_e;

    typedef enum logic [2:0] {
        SRCB_REG    = 3'b000,
        SRCB_FOUR   = 3'b001,
        SRCB_SEXT   = 3'b010,
        SRCB_BRANCH = 3'b011,
        SRCB_ZEXT   = 3'b100
    } srcb_e;

    typedef enum logic [1:0] {
        PCS_ALU    = 2'b00,
        PCS_TARGET = 2'b01,
        PCS_VECTOR = 2'b10,
        PCS_RSVD   = 2'b11
    } pcsrc_e;

    typedef struct packed {
        logic               ir_write;
        logic               mem_read;
        logic               mem_write;
        logic               iord;
        logic               pc_write;
        logic               pc_write_cond;
        pcsrc_e             pc_source;
        logic               alu_src_a;
        srcb_e              alu_src_b;
        alu_op_e            alu_op;
        logic               reg_write;
        logic               reg_dst;
        logic               mem_to_reg;
        logic               epc_write;
        logic               cause_write;
        logic [CAUSE_W-1:0] cause_code;
    } ctrl_t;

endpackage

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  state_e            cur,
    input  logic [OP_W-1:0]   opcode,
    input  logic              overflow,
    output state_e            nxt
);

    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH:   nxt = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OPC_RTYPE: nxt = ST_R_EX;
                    OPC_ORI:   nxt = ST_ORI_EX;
                    OPC_LOAD:  nxt = ST_LD_ADDR;
                    OPC_STORE: nxt = ST_ST_ADDR;
                    OPC_BEQ:   nxt = ST_BR;
                    default:   nxt = ST_TRAP_OP;
                endcase
            end
            ST_R_EX:    nxt = overflow ? ST_TRAP_OVF : ST_R_WB;
            ST_ORI_EX:  nxt = ST_ORI_WB;
            ST_LD_ADDR: nxt = ST_LD_MEM;
            ST_LD_MEM:  nxt = ST_LD_WB;
            ST_ST_ADDR: nxt = ST_ST_MEM;
            default:    nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
    import mcc_pkg::*;
#(
    parameter logic [CAUSE_W-1:0] CAUSE_UNDEF = 5'd10,
    parameter logic [CAUSE_W-1:0] CAUSE_OVF   = 5'd12
) (
    input  state_e cur,
    output ctrl_t  ctl
);

    always_comb begin
        ctl = '0;
        case (cur)
            ST_FETCH: begin
                ctl.mem_read  = 1'b1;
                ctl.ir_write  = 1'b1;
                ctl.alu_src_a = 1'b0;
                ctl.alu_src_b = SRCB_FOUR;
                ctl.alu_op    = ALU_ADD;
                ctl.pc_write  = 1'b1;
                ctl.pc_source = PCS_ALU;
            end
            ST_DECODE: begin
                ctl.alu_src_b = SRCB_BRANCH;
                ctl.alu_op    = ALU_ADD;
            end
            ST_R_EX: begin
                ctl.alu_src_a = 1'b1;
                ctl.alu_src_b = SRCB_REG;
                ctl.alu_op    = ALU_FUNCT;
            end
            ST_R_WB: begin
                ctl.reg_write = 1'b1;
                ctl.reg_dst   = 1'b1;
            end
            ST_ORI_EX: begin
                ctl.alu_src_a = 1'b1;
                ctl.alu_src_b = SRCB_ZEXT;
                ctl.alu_op    = ALU_OR;
            end
            ST_ORI_WB: begin
                ctl.reg_write = 1'b1;
            end
            ST_LD_ADDR, ST_ST_ADDR: begin
                ctl.alu_src_a = 1'b1;
                ctl.alu_src_b = SRCB_SEXT;
                ctl.alu_op    = ALU_ADD;
            end
            ST_LD_MEM: begin
                ctl.mem_read = 1'b1;
                ctl.iord     = 1'b1;
            end
            ST_LD_WB: begin
                ctl.reg_write  = 1'b1;
                ctl.mem_to_reg = 1'b1;
            end
            ST_ST_MEM: begin
                ctl.mem_write = 1'b1;
                ctl.iord      = 1'b1;
            end
            ST_BR: begin
                ctl.alu_src_a     = 1'b1;
                ctl.alu_src_b     = SRCB_REG;
                ctl.alu_op        = ALU_SUB;
                ctl.pc_write_cond = 1'b1;
                ctl.pc_source     = PCS_TARGET;
            end
            ST_TRAP_OP, ST_TRAP_OVF: begin
                ctl.alu_src_a   = 1'b0;
                ctl.alu_src_b   = SRCB_FOUR;
                ctl.alu_op      = ALU_SUB;
                ctl.epc_write   = 1'b1;
                ctl.cause_write = 1'b1;
                ctl.cause_code  = (cur == ST_TRAP_OP) ? CAUSE_UNDEF : CAUSE_OVF;
                ctl.pc_write    = 1'b1;
                ctl.pc_source   = PCS_VECTOR;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mcc_pkg::*;
#(
    parameter int                 ADDR_W       = 32,
    parameter logic [ADDR_W-1:0]  HANDLER_ADDR = 32'h8000_0180,
    parameter logic [CAUSE_W-1:0] CAUSE_UNDEF  = 5'd10,
    parameter logic [CAUSE_W-1:0] CAUSE_OVF    = 5'd12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    opcode,
    input  logic               zero,
    input  logic               overflow,
    output logic [STATE_W-1:0] state_o,
    output logic               ir_write,
    output logic               mem_read,
    output logic               mem_write,
    output logic               iord,
    output logic               pc_en,
    output logic [1:0]         pc_source,
    output logic               alu_src_a,
    output logic [2:0]         alu_src_b,
    output logic [1:0]         alu_op,
    output logic               reg_write,
    output logic               reg_dst,
    output logic               mem_to_reg,
    output logic               epc_write,
    output logic               cause_write,
    output logic [CAUSE_W-1:0] cause_code,
    output logic [ADDR_W-1:0]  handler_addr
);

    typedef struct packed {
        state_e state;
    } seq_t;

    seq_t   seq_d, seq_q;
    state_e nxt_state;
    ctrl_t  ctl;

    mcc_next_state u_next (
        .cur      (seq_q.state),
        .opcode   (opcode),
        .overflow (overflow),
        .nxt      (nxt_state)
    );

    mcc_out_decode #(
        .CAUSE_UNDEF (CAUSE_UNDEF),
        .CAUSE_OVF   (CAUSE_OVF)
    ) u_out (
        .cur (seq_q.state),
        .ctl (ctl)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.state = nxt_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_FETCH;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o      = seq_q.state;
    assign ir_write     = ctl.ir_write;
    assign mem_read     = ctl.mem_read;
    assign mem_write    = ctl.mem_write;
    assign iord         = ctl.iord;
    assign pc_en        = ctl.pc_write | (ctl.pc_write_cond & zero);
    assign pc_source    = ctl.pc_source;
    assign alu_src_a    = ctl.alu_src_a;
    assign alu_src_b    = ctl.alu_src_b;
    assign alu_op       = ctl.alu_op;
    assign reg_write    = ctl.reg_write;
    assign reg_dst      = ctl.reg_dst;
    assign mem_to_reg   = ctl.mem_to_reg;
    assign epc_write    = ctl.epc_write;
    assign cause_write  = ctl.cause_write;
    assign cause_code   = ctl.cause_code;
    assign handler_addr = HANDLER_ADDR;

endmodule

// File: rtl/mcc_checker.sv
module mcc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] state,
    input logic       overflow,
    input logic       mem_read,
    input logic       mem_write,
    input logic       reg_write,
    input logic       epc_write,
    input logic       pc_en,
    input logic [1:0] pc_source
);

    assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 4'b0000) |=> (state == 4'b0001));

    assert_mem_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_read, mem_write, reg_write, epc_write}));

    assert_store_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_write |=> (state == 4'b0000));

    assert_branch_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 4'b0010) |=> (state == 4'b0000));

    assert_trap_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        epc_write |-> (pc_en && pc_source == 2'b10));

    assert_trap_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
        epc_write |=> (state == 4'b0000));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 4'b0100 && overflow) |=> (state == 4'b1110 && !reg_write));

endmodule

bind mc_ctrl_fsm mcc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_o),
    .overflow  (overflow),
    .mem_read  (mem_read),
    .mem_write (mem_write),
    .reg_write (reg_write),
    .epc_write (epc_write),
    .pc_en     (pc_en),
    .pc_source (pc_source)
);

// File: tb/mc_ctrl_fsm_tb.sv
module mc_ctrl_fsm_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = 6'b0;
    logic        zero = 1'b0;
    logic        overflow = 1'b0;
    logic [3:0]  state_o;
    logic        ir_write, mem_read, mem_write, iord, pc_en;
    logic [1:0]  pc_source;
    logic        alu_src_a;
    logic [2:0]  alu_src_b;
    logic [1:0]  alu_op;
    logic        reg_write, reg_dst, mem_to_reg, epc_write, cause_write;
    logic [4:0]  cause_code;
    logic [31:0] handler_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    mc_ctrl_fsm u_dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .zero(zero), .overflow(overflow),
        .state_o(state_o), .ir_write(ir_write), .mem_read(mem_read), .mem_write(mem_write),
        .iord(iord), .pc_en(pc_en), .pc_source(pc_source), .alu_src_a(alu_src_a),
        .alu_src_b(alu_src_b), .alu_op(alu_op), .reg_write(reg_write), .reg_dst(reg_dst),
        .mem_to_reg(mem_to_reg), .epc_write(epc_write), .cause_write(cause_write),
        .cause_code(cause_code), .handler_addr(handler_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk_fetch(input string tag);
        chk({tag, " fetch state"}, 32'(state_o), 32'h0);
        chk({tag, " fetch ir/mem/iord"}, {ir_write, mem_read, iord}, 3'b110);
        chk({tag, " fetch pc_en/src"}, {pc_en, pc_source}, 3'b100);
        chk({tag, " fetch alu"}, {alu_src_a, alu_src_b, alu_op}, {1'b0, 3'b001, 2'b00});
    endtask

    task automatic chk_decode(input string tag);
        chk({tag, " decode state"}, 32'(state_o), 32'h1);
        chk({tag, " decode alu"}, {alu_src_a, alu_src_b, alu_op}, {1'b0, 3'b011, 2'b00});
        chk({tag, " decode no writes"}, {pc_en, reg_write, mem_write, ir_write, epc_write}, 5'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        chk_fetch("R1");
        rst_n = 1'b1;
    endtask

    task automatic t_rtype(input bit ovf);
        chk_fetch("R2");
        opcode = 6'b000000;
        step();
        chk_decode("R3");
        step();
        chk("R4 exec state", 32'(state_o), 32'h4);
        chk("R4 exec alu", {alu_src_a, alu_src_b, alu_op}, {1'b1, 3'b000, 2'b10});
        overflow = ovf;
        step();
        overflow = 1'b0;
        if (ovf) begin
            chk("R10 trap state", 32'(state_o), 32'hE);
            chk("R10 cause", {epc_write, cause_write, 27'(cause_code)}, {2'b11, 27'd12});
            chk("R10 no reg_write", 32'(reg_write), 32'h0);
            chk("R10 pc redirect", {pc_en, pc_source}, 3'b110);
            chk("R10 epc alu pc-4", {alu_src_a, alu_src_b, alu_op}, {1'b0, 3'b001, 2'b01});
        end else begin
            chk("R4 wb state", 32'(state_o), 32'h5);
            chk("R4 wb rd", {reg_write, reg_dst, mem_to_reg}, 3'b110);
        end
        step();
        chk(ovf ? "R10 return" : "R4 four cycles", 32'(state_o), 32'h0);
    endtask

    task automatic t_ori();
        opcode = 6'b001101;
        step();
        chk_decode("R3");
        step();
        chk("R5 exec state", 32'(state_o), 32'h6);
        chk("R5 exec alu", {alu_src_a, alu_src_b, alu_op}, {1'b1, 3'b100, 2'b11});
        overflow = 1'b1;
        step();
        overflow = 1'b0;
        chk("R11 overflow ignored in ori", 32'(state_o), 32'h7);
        chk("R5 wb rt", {reg_write, reg_dst, mem_to_reg, epc_write}, 4'b1000);
        step();
        chk("R5 four cycles", 32'(state_o), 32'h0);
    endtask

    task automatic t_load();
        opcode = 6'b100011;
        step();
        zero = 1'b1;
        chk("R11 zero ignored in decode", 32'(pc_en), 32'h0);
        step();
        zero = 1'b0;
        chk("R6 addr state", 32'(state_o), 32'h8);
        chk("R6 addr alu", {alu_src_a, alu_src_b, alu_op}, {1'b1, 3'b010, 2'b00});
        step();
        chk("R6 mem state", 32'(state_o), 32'h9);
        chk("R6 mem read", {mem_read, mem_write, iord}, 3'b101);
        step();
        chk("R6 wb state", 32'(state_o), 32'hA);
        chk("R6 wb mdr", {reg_write, reg_dst, mem_to_reg}, 3'b101);
        step();
        chk("R6 five cycles", 32'(state_o), 32'h0);
    endtask

    task automatic t_store();
        opcode = 6'b101011;
        step();
        step();
        chk("R7 addr state", 32'(state_o), 32'hB);
        chk("R7 addr alu", {alu_src_a, alu_src_b, alu_op}, {1'b1, 3'b010, 2'b00});
        step();
        chk("R7 mem state", 32'(state_o), 32'hC);
        chk("R7 mem write", {mem_write, mem_read, iord, reg_write}, 4'b1010);
        step();
        chk("R7 four cycles", 32'(state_o), 32'h0);
    endtask

    task automatic t_beq(input bit z);
        opcode = 6'b000100;
        step();
        step();
        zero = z;
        chk("R8 branch state", 32'(state_o), 32'h2);
        chk("R8 branch alu", {alu_src_a, alu_src_b, alu_op}, {1'b1, 3'b000, 2'b01});
        chk("R8 pc_source", 32'(pc_source), 32'h1);
        #1;
        chk("R8 pc_en follows zero", 32'(pc_en), 32'(z));
        step();
        zero = 1'b0;
        chk("R8 three cycles", 32'(state_o), 32'h0);
    endtask

    task automatic t_undef(input logic [5:0] op);
        opcode = op;
        step();
        step();
        chk("R9 trap state", 32'(state_o), 32'hD);
        chk("R9 cause 10", {epc_write, cause_write, 27'(cause_code)}, {2'b11, 27'd10});
        chk("R9 epc alu pc-4", {alu_src_a, alu_src_b, alu_op}, {1'b0, 3'b001, 2'b01});
        chk("R9 pc vector", {pc_en, pc_source}, 3'b110);
        chk("R9 handler", handler_addr, 32'h8000_0180);
        chk("R9 no side writes", {reg_write, mem_write, ir_write}, 3'b0);
        step();
        chk("R9 return", 32'(state_o), 32'h0);
    endtask

    initial begin
        step();
        t_reset();
        t_rtype(1'b0);
        t_rtype(1'b1);
        t_ori();
        t_load();
        t_store();
        t_beq(1'b1);
        t_beq(1'b0);
        t_undef(6'b111111);
        t_undef(6'b000010);
        t_rtype(1'b0);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule